// File: doc/BRIEF.md
# Prescaled Timer/Counter with PWM Output

This block is a 16-bit timer/counter for a microcontroller-class peripheral set. It advances on a tick from a programmable prescaler, whose divide value comes in on a port so that several timers can share one setting, or on falling edges of an external pin that is sampled every clock. A run bit gates all counting.

Three operating modes are available. The first is a wrapping counter whose width can be set between 9 and 16 bits. The second is a 16-bit counter that loads a reload value when it passes all-ones. The third splits the count into two bytes. The low byte runs freely, the high byte holds a compare value, and the block drives an 8-bit pulse-width-modulated output.

Each wrap raises an overflow flag for the interrupt logic. Software clears the flag with a write, or the interrupt controller clears it with an acknowledge. A small address/data port gives write and read access to the count, the reload value and the control bits.

Top module: `pwm_timer`

## Requirements
- R1: After reset the count, reload value and control register read as zero, the overflow flag is 0 and `pwmOut` is 0.
- R2: A free-running prescale counter starts from zero and restarts after it reaches (or exceeds) `prescaleSel`. In timer mode it gives one tick per `prescaleSel`+1 clocks, so `prescaleSel`=0 gives a tick on every clock. A running timer advances by one on each tick.
- R3: When control bit 3 is 1 (counter mode), the timer advances once for each high-to-low change of `extPin` seen between two consecutive clock samples, and the prescaler has no effect.
- R4: The count holds when control bit 2 (run) is 0, or when the mode field (control bits 1:0) is 3.
- R5: In mode 0, W = 9 + control bits 6:4. The low W bits of the count advance and the bits above them are cleared. When the low W bits are all ones, the next advance makes the whole count zero and sets the overflow flag.
- R6: In mode 1 the count advances through all 16 bits. The advance from 16'hFFFF loads the reload register and sets the overflow flag.
- R7: In mode 2, count bits 7:0 advance freely. The advance from 8'hFF clears them, copies reload bits 7:0 into count bits 15:8 and sets the overflow flag. `pwmOut` is 1 exactly while the mode is 2 and bits 7:0 are below bits 15:8.
- R8: A write to address 3 or a high `intAck` clears the overflow flag. An overflow in the same cycle wins, and the flag stays 1.
- R9: Address 0 is the count, address 1 the reload value and address 2 the control register (7 bits, the upper read bits are 0). A read of address 3 returns the flag in bit 0. A count write takes effect on the next clock and cancels any advance or overflow in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| prescaleSel | input | 4 | Shared prescale divide value minus one |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 2 | Register write address |
| wrData | input | 16 | Register write data |
| rdAddr | input | 2 | Register read address |
| rdData | output | 16 | Register read data |
| extPin | input | 1 | External count input |
| intAck | input | 1 | Interrupt acknowledge, clears the flag |
| ovfFlag | output | 1 | Overflow flag to the interrupt logic |
| pwmOut | output | 1 | PWM output |

## Verification
The assertions assume that `extPin` is already synchronous to `clk`. They also assume that the strobes coming from the control half are the only source of count changes. A mode or width change that lands together with an advance is judged against the configuration held before that edge. The stimulus changes every input half a cycle away from the active edge, and `extPin` toggles at most once per cycle. Random control writes may hit any mode, width and run combination, including changes in the middle of a count.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int CNT_W  = 16;
  localparam int PRE_W  = 4;
  localparam int ADDR_W = 2;
  localparam int SEL_W  = 3;
  localparam int MIN_W  = 9;
  localparam int CTRL_W = 7;
  localparam int PWM_W  = CNT_W / 2;

  localparam logic [ADDR_W-1:0] ADDR_COUNT  = 2'd0;
  localparam logic [ADDR_W-1:0] ADDR_RELOAD = 2'd1;
  localparam logic [ADDR_W-1:0] ADDR_CTRL   = 2'd2;
  localparam logic [ADDR_W-1:0] ADDR_FLAG   = 2'd3;

  typedef enum logic [1:0] {
    MODE_VARW   = 2'd0,
    MODE_RELOAD = 2'd1,
    MODE_PWM    = 2'd2,
    MODE_HALT   = 2'd3
  } tmrMode_e;

  typedef struct packed {
    logic incr;
    logic wrCount;
    logic wrReload;
    logic clrFlag;
  } tmrStrobe_t;

  typedef struct packed {
    tmrMode_e         mode;
    logic [SEL_W-1:0] widthSel;
  } tmrCfg_t;
endpackage

// File: rtl/tmr_ctrl.sv
module tmr_ctrl
  import tmr_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [PRE_W-1:0]  prescaleSel,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [CNT_W-1:0]  wrData,
  input  logic              extPin,
  input  logic              intAck,
  output tmrStrobe_t        strobe,
  output tmrCfg_t           cfg,
  output logic [CTRL_W-1:0] ctrlReg
);
  logic [PRE_W-1:0] preCnt;
  logic             preTick;
  logic             extS1, extS2;
  logic             extFall;
  logic             runBit, extSel;

  assign preTick = (preCnt >= prescaleSel);
  assign extFall = extS2 & ~extS1;
  assign runBit  = ctrlReg[2];
  assign extSel  = ctrlReg[3];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      preCnt  <= '0;
      extS1   <= 1'b0;
      extS2   <= 1'b0;
      ctrlReg <= '0;
    end else begin
      preCnt <= preTick ? '0 : preCnt + 1'b1;
      extS1  <= extPin;
      extS2  <= extS1;
      if (wrEn && wrAddr == ADDR_CTRL) ctrlReg <= wrData[CTRL_W-1:0];
    end
  end

  assign cfg.mode     = tmrMode_e'(ctrlReg[1:0]);
  assign cfg.widthSel = ctrlReg[6:4];

  always_comb begin
    strobe          = '0;
    strobe.incr     = runBit && (cfg.mode != MODE_HALT) && (extSel ? extFall : preTick);
    strobe.wrCount  = wrEn && (wrAddr == ADDR_COUNT);
    strobe.wrReload = wrEn && (wrAddr == ADDR_RELOAD);
    strobe.clrFlag  = (wrEn && (wrAddr == ADDR_FLAG)) || intAck;
  end

  AST_RUN_CLEARED_NO_INCR: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrAddr == ADDR_CTRL && !wrData[2]) |=> !strobe.incr) else $error("run gate"); // R4
endmodule

// File: rtl/tmr_datapath.sv
module tmr_datapath
  import tmr_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  tmrStrobe_t       strobe,
  input  tmrCfg_t          cfg,
  input  logic [CNT_W-1:0] wrData,
  output logic [CNT_W-1:0] count,
  output logic [CNT_W-1:0] reload,
  output logic             flag,
  output logic             pwmOut
);
  localparam logic [CNT_W:0] ONE_WIDE = {{CNT_W{1'b0}}, 1'b1};

  logic [4:0]       widthVal;
  logic [CNT_W:0]   maskWide;
  logic [CNT_W-1:0] mask;
  logic [CNT_W-1:0] nextCount;
  logic             wrapHit;
  logic             ovfEvt;
  logic [PWM_W-1:0] lowByte, highByte;

  assign widthVal = 5'(MIN_W) + {2'b00, cfg.widthSel};
  assign maskWide = (ONE_WIDE << widthVal) - ONE_WIDE;
  assign mask     = maskWide[CNT_W-1:0];
  assign lowByte  = count[PWM_W-1:0];
  assign highByte = count[CNT_W-1:PWM_W];

  always_comb begin
    nextCount = count;
    wrapHit   = 1'b0;
    case (cfg.mode)
      MODE_VARW: begin
        if ((count & mask) == mask) begin
          nextCount = '0;
          wrapHit   = 1'b1;
        end else begin
          nextCount = (count + 1'b1) & mask;
        end
      end
      MODE_RELOAD: begin
        if (count == '1) begin
          nextCount = reload;
          wrapHit   = 1'b1;
        end else begin
          nextCount = count + 1'b1;
        end
      end
      MODE_PWM: begin
        if (lowByte == '1) begin
          nextCount = {reload[PWM_W-1:0], {PWM_W{1'b0}}};
          wrapHit   = 1'b1;
        end else begin
          nextCount = {highByte, lowByte + 1'b1};
        end
      end
      default: nextCount = count;
    endcase
  end

  assign ovfEvt = strobe.incr && !strobe.wrCount && wrapHit;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      count  <= '0;
      reload <= '0;
      flag   <= 1'b0;
    end else begin
      if (strobe.wrCount)   count <= wrData;
      else if (strobe.incr) count <= nextCount;
      if (strobe.wrReload)  reload <= wrData;
      if (ovfEvt)               flag <= 1'b1;
      else if (strobe.clrFlag)  flag <= 1'b0;
    end
  end

  assign pwmOut = (cfg.mode == MODE_PWM) && (lowByte < highByte);

  AST_HOLD_STOPPED: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.incr && !strobe.wrCount) |=> $stable(count)) else $error("hold"); // R4
  AST_VARW_UPPER_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.incr && !strobe.wrCount && cfg.mode == MODE_VARW) |=> ((count & ~$past(mask)) == '0)) else $error("varw"); // R5
  AST_RELOAD_ON_WRAP: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.incr && !strobe.wrCount && cfg.mode == MODE_RELOAD && count == '1) |=> (count == $past(reload) && flag)) else $error("reload"); // R6
  AST_PWM_COMPARE_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.incr && !strobe.wrCount && cfg.mode == MODE_PWM && lowByte == '1) |=> (highByte == $past(reload[PWM_W-1:0]) && lowByte == '0)) else $error("pwm"); // R7
  AST_FLAG_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.clrFlag && !(strobe.incr && !strobe.wrCount)) |=> !flag) else $error("clear"); // R8
  AST_WRITE_WINS: assert property (@(posedge clk) disable iff (!rstN)
    strobe.wrCount |=> (count == $past(wrData))) else $error("write"); // R9
endmodule

// File: rtl/pwm_timer.sv
module pwm_timer
  import tmr_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [PRE_W-1:0]  prescaleSel,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [CNT_W-1:0]  wrData,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [CNT_W-1:0]  rdData,
  input  logic              extPin,
  input  logic              intAck,
  output logic              ovfFlag,
  output logic              pwmOut
);
  tmrStrobe_t        strobe;
  tmrCfg_t           cfg;
  logic [CTRL_W-1:0] ctrlReg;
  logic [CNT_W-1:0]  count, reload;

  tmr_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .prescaleSel(prescaleSel), .wrEn(wrEn),
    .wrAddr(wrAddr), .wrData(wrData), .extPin(extPin), .intAck(intAck),
    .strobe(strobe), .cfg(cfg), .ctrlReg(ctrlReg)
  );

  tmr_datapath u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .cfg(cfg), .wrData(wrData),
    .count(count), .reload(reload), .flag(ovfFlag), .pwmOut(pwmOut)
  );

  always_comb begin
    case (rdAddr)
      ADDR_COUNT:  rdData = count;
      ADDR_RELOAD: rdData = reload;
      ADDR_CTRL:   rdData = {{(CNT_W-CTRL_W){1'b0}}, ctrlReg};
      default:     rdData = {{(CNT_W-1){1'b0}}, ovfFlag};
    endcase
  end
endmodule

// File: tb/pwm_timer_bench.sv
`timescale 1ns/1ps
module pwm_timer_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [3:0]  prescaleSel = '0;
  logic        wrEn = 1'b0;
  logic [1:0]  wrAddr = '0;
  logic [15:0] wrData = '0;
  logic [1:0]  rdAddr = '0;
  logic [15:0] rdData;
  logic        extPin = 1'b1;
  logic        intAck = 1'b0;
  logic        ovfFlag, pwmOut;

  int nChk = 0, nErr = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  pwm_timer u_pwm_timer (
    .clk(clk), .rstN(rstN), .prescaleSel(prescaleSel), .wrEn(wrEn),
    .wrAddr(wrAddr), .wrData(wrData), .rdAddr(rdAddr), .rdData(rdData),
    .extPin(extPin), .intAck(intAck), .ovfFlag(ovfFlag), .pwmOut(pwmOut)
  );

  // Reference model written from the requirements
  logic [3:0]  mPre;
  logic        mS1, mS2;
  logic [15:0] mCount, mReload;
  logic [6:0]  mCtrl;
  logic        mFlag;
  logic        tk, fl, inc, wrap;
  logic [15:0] nc;
  int          w;
  logic [16:0] lim;

  always @(posedge clk) begin
    if (!rstN) begin
      mPre <= '0; mS1 <= 1'b0; mS2 <= 1'b0;
      mCount <= '0; mReload <= '0; mCtrl <= '0; mFlag <= 1'b0;
    end else begin
      tk = (mPre >= prescaleSel);                                 // R2
      fl = mS2 && !mS1;                                           // R3
      inc = mCtrl[2] && (mCtrl[1:0] != 2'd3) && (mCtrl[3] ? fl : tk);
      wrap = 1'b0; nc = mCount;
      case (mCtrl[1:0])
        2'd0: begin                                               // R5
          w = 9 + int'(mCtrl[6:4]);
          lim = 17'(1) << w;
          if ((17'(mCount) % lim) == lim - 1) begin nc = '0; wrap = 1'b1; end
          else nc = 16'((17'(mCount) + 17'd1) % lim);
        end
        2'd1: begin                                               // R6
          if (mCount == 16'hFFFF) begin nc = mReload; wrap = 1'b1; end
          else nc = mCount + 16'd1;
        end
        2'd2: begin                                               // R7
          if (mCount[7:0] == 8'hFF) begin nc = {mReload[7:0], 8'h00}; wrap = 1'b1; end
          else nc = {mCount[15:8], mCount[7:0] + 8'd1};
        end
        default: nc = mCount;
      endcase
      mPre <= tk ? 4'd0 : mPre + 4'd1;
      mS1 <= extPin; mS2 <= mS1;
      if (wrEn && wrAddr == 2'd0) mCount <= wrData;               // R9
      else if (inc) mCount <= nc;
      if (wrEn && wrAddr == 2'd1) mReload <= wrData;
      if (wrEn && wrAddr == 2'd2) mCtrl <= wrData[6:0];
      if (inc && wrap && !(wrEn && wrAddr == 2'd0)) mFlag <= 1'b1; // R8
      else if ((wrEn && wrAddr == 2'd3) || intAck) mFlag <= 1'b0;
    end
  end

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    nChk++;
    if (act !== exp) begin
      nErr++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic expPwm();
    return (mCtrl[1:0] == 2'd2) && (mCount[7:0] < mCount[15:8]);
  endfunction

  task automatic checkAll(input string tag);
    rdAddr = 2'd0; #1 chk({tag, " count"}, rdData, mCount);
    rdAddr = 2'd1; #1 chk({tag, " reload R9"}, rdData, mReload);
    rdAddr = 2'd2; #1 chk({tag, " ctrl R9"}, rdData, {9'd0, mCtrl});
    rdAddr = 2'd3; #1 chk({tag, " flag R8"}, rdData, {15'd0, mFlag});
    chk({tag, " pwm R7"}, {15'd0, pwmOut}, {15'd0, expPwm()});
    chk({tag, " flagPort R8"}, {15'd0, ovfFlag}, {15'd0, mFlag});
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  function automatic string modeTag(input logic [6:0] c);
    if (!c[2] || c[1:0] == 2'd3) return "R4";
    if (c[3]) return "R3";
    case (c[1:0])
      2'd0: return "R5";
      2'd1: return "R6";
      default: return "R7";
    endcase
  endfunction

  initial begin
    void'($urandom(32'd20240611));
    step(3);
    rstN = 1'b1;
    checkAll("R1");
    wr(2'd1, 16'h1234); wr(2'd0, 16'hABCD);
    checkAll("R9");
    prescaleSel = 4'd2;
    wr(2'd2, 16'h0005); step(9);
    checkAll("R2");
    prescaleSel = 4'd0; step(5);
    checkAll("R2");
    wr(2'd2, 16'h0001); step(6);
    checkAll("R4");
    wr(2'd2, 16'h0007); step(4);
    checkAll("R4");
    wr(2'd0, 16'h01FD); wr(2'd2, 16'h0004); step(3);
    checkAll("R5");
    wr(2'd0, 16'hFFFE); wr(2'd2, 16'h0074); step(3);
    checkAll("R5");
    wr(2'd3, 16'h0000);
    checkAll("R8");
    wr(2'd1, 16'h8000); wr(2'd0, 16'hFFFD); wr(2'd2, 16'h0005); step(4);
    checkAll("R6");
    intAck = 1'b1; step(1); intAck = 1'b0;
    checkAll("R8");
    // write in the cycle of a wrap: count write wins, no overflow
    wr(2'd0, 16'hFFFF); wr(2'd0, 16'h0010);
    checkAll("R9");
    wr(2'd1, 16'h0040); wr(2'd0, 16'h20F0); wr(2'd2, 16'h0006);
    for (int i = 0; i < 300; i++) begin
      chk("R7 pwm", {15'd0, pwmOut}, {15'd0, expPwm()});
      step(1);
    end
    checkAll("R7");
    prescaleSel = 4'd5;
    wr(2'd0, 16'h0000); wr(2'd2, 16'h000D);
    for (int i = 0; i < 10; i++) begin
      extPin = 1'b0; step(2); extPin = 1'b1; step(2);
    end
    checkAll("R3");
    chk("R3 edges", mCount, 16'd10);
    // random phase
    for (int i = 0; i < 6000; i++) begin
      if (i % 16 == 0) checkAll(modeTag(mCtrl));
      chk("R7 pwm", {15'd0, pwmOut}, {15'd0, expPwm()});
      wrEn = 1'b0;
      intAck = ($urandom % 30) == 0;
      if (($urandom % 3) == 0) extPin = ~extPin;
      if (($urandom % 200) == 0) prescaleSel = 4'($urandom % 4);
      case ($urandom % 60)
        0: begin wrEn = 1'b1; wrAddr = 2'd2;
             wrData = {9'd0, 3'($urandom), 1'($urandom % 4 == 0), 1'($urandom % 5 != 0), 2'($urandom)}; end
        1: begin wrEn = 1'b1; wrAddr = 2'd0;
             wrData = (($urandom % 2) != 0) ? 16'($urandom) : (16'hFFFF - 16'($urandom % 6)); end
        2: begin wrEn = 1'b1; wrAddr = 2'd1; wrData = 16'($urandom); end
        3: begin wrEn = 1'b1; wrAddr = 2'd3; wrData = 16'd0; end
        default: ;
      endcase
      step(1);
    end
    wrEn = 1'b0; intAck = 1'b0;
    checkAll(modeTag(mCtrl));
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nErr);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nChk++; nErr++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nErr);
      $finish;
    end
  end
endmodule